// File: doc/BRIEF.md
# Gapless Framed Serial Word Streamer

This block is a serial master that sends a burst of fixed-width words on a clock line and a data line. The serial clock does not pause between words. A word-sync strobe runs alongside the least significant bit of every word, so a slave can find word edges without any gap in the clock. Words come in on a parallel valid/ready port. A one-word holding register accepts the next word while the current one is shifting out. At each word boundary, the held word moves into the shift register on the same falling clock edge that ends the previous word's LSB.

The serial clock is the system clock divided by a programmable amount. Data changes on the falling edge of the serial clock, and the slave samples it on the rising edge. A start pulse opens a burst. A done pulse closes the burst after the last word's LSB. If the holding register is empty at a boundary, the block raises an underrun pulse and ends the burst early. On the same rising edges, the block samples a serial input line. It assembles the bits MSB first and presents each received word with a one-cycle valid pulse.

Top module: `gapless_word_streamer`

## Requirements
- R1: Outside a burst (after reset, after done, after underrun), ser_clk, ser_out and word_sync are all low.
- R2: Each 16-bit word is sent most significant bit first. ser_out changes only when ser_clk falls (or at burst start) and holds its value while ser_clk is high.
- R3: From the first rising edge of a burst to its last, consecutive rising edges of ser_clk are exactly 2*(half_div+1) system clocks apart. This includes the steps across word boundaries.
- R4: word_sync is high during the bit period of bit index 15 (the LSB) of every word and low for the other 15 bits. Sampled at each ser_clk rising edge, it is 1 exactly on the 16th bit.
- R5: A burst that is never starved carries exactly 1024 words (16384 rising edges). It then gives a single one-cycle done pulse, and busy drops.
- R6: If no word is held when the falling edge ending a word's LSB arrives, the burst ends after that word. The block gives a one-cycle underrun pulse and no done pulse.
- R7: A start pulse while the holding register is empty produces an underrun pulse and no serial clock edge.
- R8: A start pulse during a burst has no effect: the word count, the timing and the done pulse are unchanged.
- R9: ser_in is sampled at each ser_clk rising edge and assembled MSB first. After the rising edge of each word's LSB, rx_data carries the word with a one-cycle rx_valid pulse.
- R10: A word is accepted when in_valid and in_ready are both high. in_ready is high exactly while the single holding register is empty, so each burst accepts exactly the number of words it sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_div | input | DIV_W | System clocks per serial half-period, minus one |
| start | input | 1 | Pulse that opens a burst |
| in_valid | input | 1 | Transmit word offered |
| in_data | input | WORD_W | Transmit word |
| in_ready | output | 1 | Holding register empty |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_out | output | 1 | Serial data out, MSB first |
| word_sync | output | 1 | High during each word's LSB |
| ser_in | input | 1 | Serial data in |
| rx_data | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle pulse with a new rx_data |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse after the last word of a full burst |
| underrun | output | 1 | One-cycle pulse when a burst is starved |

## Verification
The main function runs as one full 1024-word burst at the fastest divider. Every bit, sync level and rising-edge spacing is checked, which separates a gapless clock from one that stalls at word boundaries and an LSB-aligned strobe from a between-word pulse. Short starved bursts with dividers 1 to 3 run the boundary logic at several half-periods. The word count at which they stop separates a correct underrun from an off-by-one that sends one word too many or too few. An empty-start case and a start pulse fired mid-burst check that starting with no word aborts cleanly and that a repeated start is ignored.

// File: rtl/gws_pkg.sv
package gws_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } run_state_e;
endpackage

// File: rtl/gws_clkdiv.sv
module gws_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_div,
   output logic             sclk,
   output logic             rise_evt,
   output logic             fall_evt
);
   logic [DIV_W-1:0] cnt_q;
   logic             sclk_q;
   logic             term;

   assign term     = run && (cnt_q == half_div);
   assign rise_evt = term && !sclk_q;
   assign fall_evt = term && sclk_q;
   assign sclk     = sclk_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_q  <= '0;
         sclk_q <= 1'b0;
      end else if (term) begin
         cnt_q  <= '0;
         sclk_q <= ~sclk_q;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   // serial clock rests low whenever no burst runs
   assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !sclk_q);
endmodule

// File: rtl/gws_tx.sv
module gws_tx #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              in_ready,
   input  logic              take,
   input  logic              shift,
   output logic              avail,
   output logic              msb
);
   logic [WORD_W-1:0] hold_q;
   logic [WORD_W-1:0] sr_q;
   logic              full_q;

   assign in_ready = !full_q;
   assign avail    = full_q;
   assign msb      = sr_q[WORD_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
         full_q <= 1'b0;
      end else if (in_valid && !full_q) begin
         hold_q <= in_data;
         full_q <= 1'b1;
      end else if (take) begin
         full_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sr_q <= '0;
      else if (take) sr_q <= hold_q;
      else if (shift) sr_q <= {sr_q[WORD_W-2:0], 1'b0};
   end

   // one word of look-ahead: an accepted word fills the register
   assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);
endmodule

// File: rtl/gws_rx.sv
module gws_rx #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample,
   input  logic              last,
   input  logic              sdi,
   output logic [WORD_W-1:0] word,
   output logic              valid
);
   logic [WORD_W-1:0] sr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q  <= '0;
         word  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (sample) begin
            sr_q <= {sr_q[WORD_W-2:0], sdi};
            if (last) begin
               word  <= {sr_q[WORD_W-2:0], sdi};
               valid <= 1'b1;
            end
         end
      end
   end

   assert_rx_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
endmodule

// File: rtl/gapless_word_streamer.sv
module gapless_word_streamer
   import gws_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int BURST_LEN = 1024,
   parameter int DIV_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  half_div,
   input  logic              start,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              in_ready,
   output logic              ser_clk,
   output logic              ser_out,
   output logic              word_sync,
   input  logic              ser_in,
   output logic [WORD_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              busy,
   output logic              done,
   output logic              underrun
);
   localparam int BIT_W  = $clog2(WORD_W);
   localparam int WCNT_W = $clog2(BURST_LEN);
   localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);
   localparam logic [WCNT_W-1:0] LAST_WORD = WCNT_W'(BURST_LEN - 1);

   if (WORD_W < 2) begin : g_bad_word
      $error("WORD_W must be at least 2");
   end
   if (BURST_LEN < 2) begin : g_bad_len
      $error("BURST_LEN must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end

   run_state_e        st_q, st_d;
   logic [BIT_W-1:0]  bit_q, bit_d;
   logic [WCNT_W-1:0] word_q, word_d;
   logic              sync_q, done_q, err_q, done_d, err_d;
   logic              take, shift, avail, tx_msb, rise, fall, running;

   assign running = (st_q == ST_RUN);

   gws_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(running), .half_div(half_div),
      .sclk(ser_clk), .rise_evt(rise), .fall_evt(fall));

   gws_tx #(.WORD_W(WORD_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .take(take), .shift(shift), .avail(avail),
      .msb(tx_msb));

   gws_rx #(.WORD_W(WORD_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .sample(rise && running),
      .last(bit_q == LAST_BIT), .sdi(ser_in), .word(rx_data),
      .valid(rx_valid));

   always_comb begin
      st_d   = st_q;
      bit_d  = bit_q;
      word_d = word_q;
      done_d = 1'b0;
      err_d  = 1'b0;
      take   = 1'b0;
      shift  = 1'b0;
      if (!running) begin
         if (start) begin
            if (avail) begin
               st_d   = ST_RUN;
               bit_d  = '0;
               word_d = '0;
               take   = 1'b1;
            end else begin
               err_d = 1'b1;
            end
         end
      end else if (fall) begin
         if (bit_q == LAST_BIT) begin
            if (word_q == LAST_WORD) begin
               st_d   = ST_IDLE;
               done_d = 1'b1;
            end else if (avail) begin
               take   = 1'b1;
               bit_d  = '0;
               word_d = word_q + 1'b1;
            end else begin
               st_d  = ST_IDLE;
               err_d = 1'b1;
            end
         end else begin
            shift = 1'b1;
            bit_d = bit_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         bit_q  <= '0;
         word_q <= '0;
         sync_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         bit_q  <= bit_d;
         word_q <= word_d;
         sync_q <= (st_d == ST_RUN) && (bit_d == LAST_BIT);
         done_q <= done_d;
         err_q  <= err_d;
      end
   end

   assign ser_out   = tx_msb && running;
   assign word_sync = sync_q;
   assign busy      = running;
   assign done      = done_q;
   assign underrun  = err_q;

   assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_out));
   assert_sync_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word_sync) |-> !ser_clk);
   assert_done_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_exclusive_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && underrun));
   assert_abort_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |-> (!ser_clk && !word_sync));
endmodule

// File: tb/gapless_word_streamer_test.sv
module gapless_word_streamer_test;
   localparam int W = 16;
   localparam int N = 1024;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   half_div = '0;
   logic         start = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_data = '0;
   logic         in_ready, ser_clk, ser_out, word_sync, rx_valid, busy, done, underrun;
   logic         ser_in = 1'b0;
   logic [W-1:0] rx_data;

   int checks = 0, failures = 0, cyc = 0;
   int cur_div = 0, sup_lim = 0, sup_idx = 0, accepted = 0;
   int rises = 0, falls = 0, last_rise = 0, dones = 0, errs = 0, rxn = 0;
   logic mon_clr = 1'b0, hs = 1'b0, sclk_prev = 1'b0, wd_fired = 1'b0;

   gapless_word_streamer uut (
      .clk(clk), .rst_n(rst_n), .half_div(half_div), .start(start),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .ser_clk(ser_clk), .ser_out(ser_out), .word_sync(word_sync),
      .ser_in(ser_in), .rx_data(rx_data), .rx_valid(rx_valid),
      .busy(busy), .done(done), .underrun(underrun));

   always #2 clk = ~clk;

   function automatic logic [W-1:0] tx_word(int k);
      return W'(k * 40503 + 17) ^ 16'h5A5A;
   endfunction
   function automatic logic [W-1:0] rx_word(int k);
      return W'(k * 2654 + 991) ^ 16'hC3A5;
   endfunction
   function automatic logic rx_bit(int i);
      logic [W-1:0] w;
      w = rx_word(i / W);
      return w[W-1-(i%W)];
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      hs  <= in_valid && in_ready;
   end

   // supplier: counts accepted words, offers the next one
   always @(negedge clk) begin
      if (mon_clr) begin
         sup_idx  = 0;
         accepted = 0;
      end else if (hs) begin
         sup_idx++;
         accepted++;
      end
      in_valid = (sup_idx < sup_lim);
      in_data  = tx_word(sup_idx);
   end

   // slave model and bit-level checks
   always @(negedge clk) begin
      if (mon_clr) begin
         rises = 0; falls = 0; last_rise = 0; dones = 0; errs = 0; rxn = 0;
         ser_in = rx_bit(0);
      end else begin
         if (ser_clk && !sclk_prev) begin
            logic [W-1:0] ew;
            int b;
            ew = tx_word(rises / W);
            b  = W - 1 - (rises % W);
            chk(ser_out == ew[b], "R2", "ser_out bit", int'(ser_out), int'(ew[b]));
            chk(word_sync == (b == 0), "R4", "word_sync at bit", int'(word_sync), int'(b == 0));
            if (rises > 0)
               chk(cyc - last_rise == 2 * (cur_div + 1), "R3", "rise spacing",
                   cyc - last_rise, 2 * (cur_div + 1));
            last_rise = cyc;
            rises++;
         end
         if (!ser_clk && sclk_prev) begin
            falls++;
            ser_in = rx_bit(falls);
         end
         if (done) dones++;
         if (underrun) errs++;
         if (rx_valid) begin
            chk(rx_data == rx_word(rxn), "R9", "rx word", int'(rx_data), int'(rx_word(rxn)));
            rxn++;
         end
      end
      sclk_prev = ser_clk;
      if (cyc > 120000 && !wd_fired) begin
         wd_fired = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 120000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic run_burst(int div, int lim, int exp_words, bit exp_err, bit poke);
      @(posedge clk);
      mon_clr = 1'b1;
      @(posedge clk);
      mon_clr = 1'b0;
      @(negedge clk);
      half_div = 8'(div);
      cur_div  = div;
      sup_lim  = lim;
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int n = 0; n < 110000 && busy; n++) begin
         start = poke && (n == 3000);   // R8: start during burst
         @(negedge clk);
      end
      start = 1'b0;
      repeat (4) @(negedge clk);
      chk(rises == exp_words * W, exp_err ? "R6" : "R5", "rising edges", rises, exp_words * W);
      chk(dones == (exp_err ? 0 : 1), "R5", "done pulses", dones, exp_err ? 0 : 1);
      chk(errs == (exp_err ? 1 : 0), exp_words == 0 ? "R7" : "R6", "underrun pulses",
          errs, exp_err ? 1 : 0);
      chk(rxn == exp_words, "R9", "rx words", rxn, exp_words);
      chk(accepted == lim, "R10", "accepted words", accepted, lim);
      chk(!ser_clk && !ser_out && !word_sync && !busy, "R1", "idle outputs",
          int'({ser_clk, ser_out, word_sync, busy}), 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      chk(!ser_clk && !ser_out && !word_sync && !busy, "R1", "reset outputs",
          int'({ser_clk, ser_out, word_sync, busy}), 0);
      chk(!done && !underrun && !rx_valid, "R1", "reset pulses",
          int'({done, underrun, rx_valid}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R10", "in_ready after reset", int'(in_ready), 1);
      run_burst(0, 0, 0, 1'b1, 1'b0);      // R7 empty start
      run_burst(0, N, N, 1'b0, 1'b1);      // R5 full burst with R8 poke
      run_burst(1, 3, 3, 1'b1, 1'b0);      // R6 starved
      run_burst(2, 2, 2, 1'b1, 1'b0);
      run_burst(3, 1, 1, 1'b1, 1'b0);
      run_burst(0, 5, 5, 1'b1, 1'b0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule